// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block sits between one processor and a shared system bus. It keeps a small direct-mapped data cache coherent with the other agents on the bus by watching their traffic. The processor side takes one word read or write at a time and holds the request until the controller answers with a one-cycle ready pulse. On the bus side the controller raises a request and waits for a grant. In the granted cycle it places one command on the bus: a line read, a write-back of a dirty line, or an address-only invalidate.

Each line is invalid, shared (clean) or modified (dirty). A processor write to a shared line first broadcasts an invalidate so that no other cache keeps a stale copy. When another agent's invalidate names a line held here, that line is dropped. When another agent reads a line held here as modified, the controller does not supply the data. It drives a retry response that aborts that read, writes the line back to memory, and keeps the line as shared. The retried agent reissues its read later and gets the current value from memory. The controller treats a retry on its own read the same way and reissues the read.

Addresses are word addresses. The low bits of the address select the line and the remaining bits form the tag. The processor must hold its request fields stable until it sees ready.

Top module: `snoop_cache`

## Requirements
- R1: A processor read that misses issues a bus read (command 01) of the requested address and fills the line as shared. The read data returned with ready equals memory's value. A later foreign read of that address gets no retry, and a repeated processor read hits with no bus traffic.
- R2: A processor write to a line held as shared issues an invalidate (command 11) carrying the line address, with all-zero write data, before the write completes.
- R3: A foreign invalidate whose address matches a valid line here makes that line invalid. A processor request for that address gets no ready in the following cycle.
- R4: A processor read of a line that was invalidated by a foreign invalidate issues a new bus read and returns the value now in memory.
- R5: retryOut is high in exactly the cycles where a foreign bus read (snpCmd 01) addresses a line held here as modified.
- R6: After a retry, the next own bus command is a write-back (command 10) of that line carrying its latest data. The line stays shared: a later foreign read gets no retry, and a processor read of it hits with no bus read.
- R7: When busRetryIn is high in the cycle of the controller's own bus read, no fill takes place. The controller reissues the read and completes with memory's value.
- R8: In any cycle where a foreign command is on the bus, cpuReady stays low. The stalled request completes once the bus is idle.
- R9: A processor write to a line held as modified completes without any bus command.
- R10: A miss whose target line holds a different, modified tag first writes that line back (command 10, old address and data), then reads the new line.
- R11: A processor write that misses issues a bus read and then an invalidate of the address. The line then holds the written word as modified.
- R12: A bus command other than 00 appears only in a cycle where both busReq and busGnt are high. While no grant arrives and no foreign command appears, busReq stays high.
- R13: After reset all lines are invalid, and cpuReady, busReq, retryOut and busCmd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request valid, held until ready |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Processor word address |
| cpuWdata | input | 32 | Processor write word |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read word, valid with cpuReady |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Grant, the cycle of own bus command |
| busCmd | output | 2 | Own command: 00 idle, 01 read, 10 write-back, 11 invalidate |
| busAddr | output | 32 | Address of own command |
| busWdata | output | 32 | Write-back data, zero otherwise |
| busRdata | input | 32 | Memory read data in the granted read cycle |
| busRetryIn | input | 1 | Retry from another agent against own read |
| snpCmd | input | 2 | Foreign command on the bus, same encoding |
| snpAddr | input | 32 | Address of the foreign command |
| retryOut | output | 1 | Retry driven against a foreign read |

## Verification
The checker checks several properties on every cycle. Bus commands appear only in granted cycles, and the bus request holds until a grant. Invalidates carry no data. Retry is raised only against foreign reads. A processor completion never coincides with foreign traffic or directly follows a matching invalidate. Once a retry has been given, no own read starts before the write-back of that line. The bench's per-cycle line-state model compares retryOut with its own copy of the line states. It also checks that invalidates target shared lines and that write-backs carry the current coherent value. Directed scenarios show the rest: the order of write-back, read and invalidate on misses, the reissue after a retried read, memory contents after a flush, and the recovery of a stalled request.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WBACK = 2'b10,
    CMD_INVAL = 2'b11
  } busCmd_t;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_MOD = 2'b10
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillLine;    // load tag and memory word, state shared
    logic markMod;     // own invalidate done, state modified
    logic writeWord;   // processor word write, state modified
    logic dropLine;    // evicted after write-back
    logic cleanFlush;  // retry-driven flush done, back to shared
    logic snoopKill;   // foreign invalidate hit
    logic flushSel;    // bus address/data from the flush line
  } dpStrobe_t;

endpackage

// File: rtl/snoop_cache_dp.sv
module snoop_cache_dp
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [DATA_W-1:0]         cpuWdata,
  input  logic [ADDR_W-1:0]         snpAddr,
  input  logic [$clog2(LINES)-1:0]  flushIdx,
  input  logic [DATA_W-1:0]         busRdata,
  input  logic [1:0]                busCmdOut,
  output lineState_t                cpuLineState,
  output lineState_t                victimState,
  output lineState_t                snpState,
  output lineState_t                flushState,
  output logic [DATA_W-1:0]         cpuRdata,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busWdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  lineState_t        stView   [LINES];
  logic [TAG_W-1:0]  tagView  [LINES];
  logic [DATA_W-1:0] dataView [LINES];

  generate
    for (genvar g = 0; g < LINES; g++) begin : gLine
      lineState_t        st;
      logic [TAG_W-1:0]  tag;
      logic [DATA_W-1:0] word;
      logic hereCpu, hereSnp, hereFl;

      assign hereCpu = (cpuIdx == IDX_W'(g));
      assign hereSnp = (snpIdx == IDX_W'(g));
      assign hereFl  = (flushIdx == IDX_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          st  <= LINE_INV;
          tag <= '0;
        end else if (strobe.snoopKill && hereSnp) begin
          st <= LINE_INV;
        end else if (strobe.cleanFlush && hereFl) begin
          st <= LINE_SHR;
        end else if (hereCpu) begin
          if (strobe.fillLine) begin
            st  <= LINE_SHR;
            tag <= cpuTag;
          end else if (strobe.markMod || strobe.writeWord) begin
            st <= LINE_MOD;
          end else if (strobe.dropLine) begin
            st <= LINE_INV;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (hereCpu && strobe.fillLine)       word <= busRdata;
        else if (hereCpu && strobe.writeWord) word <= cpuWdata;
      end

      assign stView[g]   = st;
      assign tagView[g]  = tag;
      assign dataView[g] = word;
    end
  endgenerate

  assign victimState  = stView[cpuIdx];
  assign cpuLineState = (tagView[cpuIdx] == cpuTag) ? stView[cpuIdx] : LINE_INV;
  assign snpState     = (tagView[snpIdx] == snpTag) ? stView[snpIdx] : LINE_INV;
  assign flushState   = stView[flushIdx];
  assign cpuRdata     = dataView[cpuIdx];

  logic [DATA_W-1:0] wbWord;
  always_comb begin
    if (strobe.flushSel) begin
      busAddr = {tagView[flushIdx], flushIdx};
      wbWord  = dataView[flushIdx];
    end else begin
      busAddr = (busCmdOut == CMD_WBACK) ? {tagView[cpuIdx], cpuIdx} : cpuAddr;
      wbWord  = dataView[cpuIdx];
    end
    busWdata = (busCmdOut == CMD_WBACK) ? wbWord : '0;
  end

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snoop_cache_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  lineState_t       cpuLineState,
  input  lineState_t       victimState,
  input  lineState_t       snpState,
  input  lineState_t       flushState,
  input  logic [1:0]       snpCmd,
  input  logic [IDX_W-1:0] snpIdx,
  input  logic             busGnt,
  input  logic             busRetryIn,
  output dpStrobe_t        strobe,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic             cpuReady,
  output logic             retryOut,
  output logic [IDX_W-1:0] flushIdx
);
  typedef enum logic {ST_LOOK, ST_BUS} ctrlState_t;

  ctrlState_t curSt, nextSt;
  busCmd_t    opReg, nextOp;
  logic       opFlush, nextFlush;
  logic       flushPend, flushDone;
  logic       snoopBusy;

  assign snoopBusy = (snpCmd != CMD_IDLE);
  assign retryOut  = (snpCmd == CMD_READ) && (snpState == LINE_MOD);
  assign busReq    = (curSt == ST_BUS);

  always_comb begin
    strobe           = '0;
    nextSt           = curSt;
    nextOp           = opReg;
    nextFlush        = opFlush;
    cpuReady         = 1'b0;
    busCmd           = CMD_IDLE;
    flushDone        = 1'b0;
    strobe.snoopKill = (snpCmd == CMD_INVAL) && (snpState != LINE_INV);
    strobe.flushSel  = opFlush && (curSt == ST_BUS);
    case (curSt)
      ST_LOOK: begin
        if (!snoopBusy) begin
          if (flushPend) begin
            if (flushState == LINE_MOD) begin
              nextSt    = ST_BUS;
              nextOp    = CMD_WBACK;
              nextFlush = 1'b1;
            end else begin
              flushDone = 1'b1;
            end
          end else if (cpuReq) begin
            nextFlush = 1'b0;
            if (cpuLineState != LINE_INV && !cpuWe) begin
              cpuReady = 1'b1;
            end else if (cpuLineState == LINE_MOD) begin
              cpuReady         = 1'b1;
              strobe.writeWord = 1'b1;
            end else if (cpuLineState == LINE_SHR) begin
              nextSt = ST_BUS;
              nextOp = CMD_INVAL;
            end else if (victimState == LINE_MOD) begin
              nextSt = ST_BUS;
              nextOp = CMD_WBACK;
            end else begin
              nextSt = ST_BUS;
              nextOp = CMD_READ;
            end
          end
        end
      end
      ST_BUS: begin
        if (snoopBusy) begin
          nextSt = ST_LOOK;
        end else if (busGnt) begin
          busCmd = opReg;
          nextSt = ST_LOOK;
          case (opReg)
            CMD_READ:  strobe.fillLine = !busRetryIn;
            CMD_WBACK: begin
              if (opFlush) begin
                strobe.cleanFlush = 1'b1;
                flushDone         = 1'b1;
              end else begin
                strobe.dropLine = 1'b1;
              end
            end
            CMD_INVAL: strobe.markMod = 1'b1;
            default:   ;
          endcase
        end
      end
      default: nextSt = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSt     <= ST_LOOK;
      opReg     <= CMD_IDLE;
      opFlush   <= 1'b0;
      flushPend <= 1'b0;
      flushIdx  <= '0;
    end else begin
      curSt   <= nextSt;
      opReg   <= nextOp;
      opFlush <= nextFlush;
      if (flushDone) begin
        flushPend <= 1'b0;
      end else if (retryOut && !flushPend) begin
        flushPend <= 1'b1;
        flushIdx  <= snpIdx;
      end
    end
  end

endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busRetryIn,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              retryOut
);
  localparam int IDX_W = $clog2(LINES);

  dpStrobe_t        strobe;
  lineState_t       cpuLineState, victimState, snpState, flushState;
  logic [IDX_W-1:0] flushIdx;

  snoop_cache_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .cpuLineState (cpuLineState),
    .victimState  (victimState),
    .snpState     (snpState),
    .flushState   (flushState),
    .snpCmd       (snpCmd),
    .snpIdx       (snpAddr[IDX_W-1:0]),
    .busGnt       (busGnt),
    .busRetryIn   (busRetryIn),
    .strobe       (strobe),
    .busReq       (busReq),
    .busCmd       (busCmd),
    .cpuReady     (cpuReady),
    .retryOut     (retryOut),
    .flushIdx     (flushIdx)
  );

  snoop_cache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cpuAddr      (cpuAddr),
    .cpuWdata     (cpuWdata),
    .snpAddr      (snpAddr),
    .flushIdx     (flushIdx),
    .busRdata     (busRdata),
    .busCmdOut    (busCmd),
    .cpuLineState (cpuLineState),
    .victimState  (victimState),
    .snpState     (snpState),
    .flushState   (flushState),
    .cpuRdata     (cpuRdata),
    .busAddr      (busAddr),
    .busWdata     (busWdata)
  );

endmodule

// File: rtl/snoop_cache_chk.sv
module snoop_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              retryOut
);
  // tracks a retry that still owes its write-back
  logic              flushOwed;
  logic [ADDR_W-1:0] owedAddr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushOwed <= 1'b0;
      owedAddr  <= '0;
    end else if (flushOwed && busCmd == 2'b10 && busAddr == owedAddr) begin
      flushOwed <= 1'b0;
    end else if (!flushOwed && retryOut) begin
      flushOwed <= 1'b1;
      owedAddr  <= snpAddr;
    end
  end

  p_cmd_in_grant_r12: assert property (@(posedge clk) disable iff (!rstN)
    busCmd != 2'b00 |-> busReq && busGnt);

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt && snpCmd == 2'b00 |=> busReq);

  p_inv_no_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    busCmd == 2'b11 |-> busWdata == '0 && busAddr == cpuAddr);

  p_retry_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    retryOut |-> snpCmd == 2'b01);

  p_snoop_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    snpCmd != 2'b00 |-> !cpuReady);

  p_ready_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  p_inv_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    snpCmd == 2'b11 && cpuReq && snpAddr == cpuAddr
      |=> !(cpuReady && cpuAddr == $past(cpuAddr)));

  p_flush_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushOwed |-> busCmd != 2'b01);

endmodule

bind snoop_cache snoop_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuReady (cpuReady),
  .cpuAddr  (cpuAddr),
  .busReq   (busReq),
  .busGnt   (busGnt),
  .busCmd   (busCmd),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .snpCmd   (snpCmd),
  .snpAddr  (snpAddr),
  .retryOut (retryOut)
);

// File: tb/snoop_cache_bench.sv
module snoop_cache_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, cpuReq, cpuWe, cpuReady, busReq, busGnt, busRetryIn, retryOut;
  logic [31:0] cpuAddr, cpuWdata, cpuRdata, busAddr, busWdata, busRdata, snpAddr;
  logic [1:0]  busCmd, snpCmd;

  snoop_cache u_snoop_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .busReq(busReq),
    .busGnt(busGnt), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRetryIn(busRetryIn), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .retryOut(retryOut)
  );

  int total = 0;
  int bad   = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, arbiter and foreign agent
  logic [31:0] mem   [64];
  logic [31:0] truth [64];
  logic        gntBlock = 1'b0;
  logic        fWr = 1'b0;
  logic [5:0]  fAddr = '0;
  logic [31:0] fData = '0;
  logic [31:0] retryAddr = 32'hffff_ffff;
  int          retryBudget = 0;
  int          retriesGiven = 0;

  function automatic logic [31:0] seedVal(int i);
    return 32'h1000 + 32'(i * 7);
  endfunction

  assign busRdata   = mem[busAddr[5:0]];
  assign busGnt     = busReq && snpCmd == 2'b00 && !gntBlock;
  assign busRetryIn = busCmd == 2'b01 && busAddr == retryAddr && retriesGiven < retryBudget;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= seedVal(i);
    end else begin
      if (busCmd == 2'b10) mem[busAddr[5:0]] <= busWdata;
      if (fWr) mem[fAddr] <= fData;
      if (busRetryIn) retriesGiven <= retriesGiven + 1;
    end
  end

  // behavioural line-state model: 1 shared, 2 modified, absent invalid
  int modelSt [int];
  int cmdQ [$];
  int addrQ [$];

  always @(posedge clk) begin
    if (rstN) begin
      bit expR;
      int a;
      a = int'(busAddr);
      expR = snpCmd == 2'b01 && modelSt.exists(int'(snpAddr)) && modelSt[int'(snpAddr)] == 2;
      chk(retryOut == expR, "R5 retry per cycle", 32'(retryOut), 32'(expR));
      if (busCmd != 2'b00) begin
        cmdQ.push_back(int'(busCmd));
        addrQ.push_back(a);
      end
      if (busCmd == 2'b11) begin
        chk(modelSt.exists(a) && modelSt[a] == 1, "R2 invalidate of shared line", busAddr, busAddr);
        modelSt[a] = 2;
      end
      if (busCmd == 2'b10) begin
        chk(modelSt.exists(a) && modelSt[a] == 2, "R10 write-back of modified line", busAddr, busAddr);
        chk(busWdata == truth[a], "R6 write-back data", busWdata, truth[a]);
        modelSt[a] = 1;
      end
      if (busCmd == 2'b01 && !busRetryIn) begin
        for (int k = 0; k < 64; k++)
          if (k % 16 == a % 16 && modelSt.exists(k)) modelSt.delete(k);
        modelSt[a] = 1;
      end
      if (snpCmd == 2'b11 && modelSt.exists(int'(snpAddr))) modelSt.delete(int'(snpAddr));
      if (cpuReady && cpuWe)
        chk(modelSt.exists(int'(cpuAddr)) && modelSt[int'(cpuAddr)] == 2, "R9 write completes on modified line", cpuAddr, cpuAddr);
      if (cpuReady && !cpuWe)
        chk(cpuRdata == truth[cpuAddr[5:0]], "R1 read data", cpuRdata, truth[cpuAddr[5:0]]);
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int countCmd(int c, int a);
    int n = 0;
    foreach (cmdQ[i]) if (cmdQ[i] == c && addrQ[i] == a) n++;
    return n;
  endfunction

  function automatic int firstCmd(int c, int a, int from);
    for (int i = from; i < cmdQ.size(); i++) if (cmdQ[i] == c && addrQ[i] == a) return i;
    return -1;
  endfunction

  task automatic cpuDo(input bit we, input int a, input logic [31:0] d, output logic [31:0] rd);
    int n = 0;
    bit got = 0;
    rd = '0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = 32'(a); cpuWdata = d;
    while (!got && n < 300) begin
      #4;
      if (cpuReady) begin
        got = 1;
        rd = cpuRdata;
      end
      @(negedge clk);
      n++;
    end
    cpuReq = 1'b0;
    if (!got) chk(0, "R8 request never completed", 32'(n), 32'(300));
    if (we) truth[a] = d;
  endtask

  task automatic foreignRead(input int a, output bit retried, output logic [31:0] d);
    @(negedge clk);
    snpCmd = 2'b01; snpAddr = 32'(a);
    #4;
    retried = retryOut;
    d = mem[a];
    @(negedge clk);
    snpCmd = 2'b00;
  endtask

  task automatic foreignWrite(input int a, input logic [31:0] v);
    @(negedge clk);
    snpCmd = 2'b11; snpAddr = 32'(a);
    fWr = 1'b1; fAddr = 6'(a); fData = v;
    truth[a] = v;
    @(negedge clk);
    snpCmd = 2'b00; fWr = 1'b0;
  endtask

  initial begin
    logic [31:0] rd, fd;
    bit rt;
    int nRd, nWb, iA, iB;
    for (int i = 0; i < 64; i++) truth[i] = seedVal(i);
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    snpCmd = 2'b00; snpAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #4;
    // R13 reset state
    chk(!cpuReady && !busReq && !retryOut && busCmd == 2'b00, "R13 outputs idle after reset",
        {28'd0, cpuReady, busReq, retryOut, |busCmd}, 32'd0);
    foreignRead(5, rt, fd);
    chk(!rt, "R13 no line valid after reset", 32'(rt), 32'd0);

    // R1 read miss then shared
    cpuDo(0, 5, 0, rd);
    chk(rd == truth[5], "R1 read miss value", rd, truth[5]);
    chk(countCmd(1, 5) == 1, "R1 one bus read", 32'(countCmd(1, 5)), 32'd1);
    foreignRead(5, rt, fd);
    chk(!rt, "R1 shared line not retried", 32'(rt), 32'd0);
    nRd = cmdQ.size();
    cpuDo(0, 5, 0, rd);
    chk(cmdQ.size() == nRd, "R1 hit without bus traffic", 32'(cmdQ.size()), 32'(nRd));

    // R2 write to shared, R9 write to modified
    cpuDo(1, 5, 32'hA5A5_0001, rd);
    chk(countCmd(3, 5) == 1, "R2 invalidate issued", 32'(countCmd(3, 5)), 32'd1);
    nRd = cmdQ.size();
    cpuDo(1, 5, 32'hB0B0_0002, rd);
    chk(cmdQ.size() == nRd, "R9 no bus command on modified hit", 32'(cmdQ.size()), 32'(nRd));

    // R5 retry, R6 flush, R7 reissue by requester
    nWb = countCmd(2, 5);
    foreignRead(5, rt, fd);
    chk(rt, "R5 foreign read of modified line retried", 32'(rt), 32'd1);
    repeat (4) @(negedge clk);
    chk(countCmd(2, 5) == nWb + 1, "R6 flush write-back", 32'(countCmd(2, 5)), 32'(nWb + 1));
    chk(mem[5] == 32'hB0B0_0002, "R6 memory holds flushed word", mem[5], 32'hB0B0_0002);
    foreignRead(5, rt, fd);
    chk(!rt && fd == 32'hB0B0_0002, "R6 reissued foreign read gets current value", fd, 32'hB0B0_0002);
    nRd = countCmd(1, 5);
    cpuDo(0, 5, 0, rd);
    chk(countCmd(1, 5) == nRd && rd == 32'hB0B0_0002, "R6 line kept shared", rd, 32'hB0B0_0002);

    // R3 / R4 foreign invalidate then re-read
    foreignWrite(5, 32'hC0C0_0003);
    nRd = countCmd(1, 5);
    cpuDo(0, 5, 0, rd);
    chk(rd == 32'hC0C0_0003, "R4 read after invalidate gets memory value", rd, 32'hC0C0_0003);
    chk(countCmd(1, 5) == nRd + 1, "R3 invalidated line misses", 32'(countCmd(1, 5)), 32'(nRd + 1));

    // R11 write miss, R10 dirty eviction
    iA = cmdQ.size();
    cpuDo(1, 7, 32'hD0D0_0004, rd);
    iB = firstCmd(1, 7, iA);
    chk(iB >= 0 && firstCmd(3, 7, iA) > iB, "R11 read before invalidate",
        32'(firstCmd(3, 7, iA)), 32'(iB));
    iA = cmdQ.size();
    cpuDo(0, 23, 0, rd);
    iB = firstCmd(2, 7, iA);
    chk(iB >= 0 && firstCmd(1, 23, iA) > iB, "R10 write-back before read",
        32'(firstCmd(1, 23, iA)), 32'(iB));
    chk(mem[7] == 32'hD0D0_0004, "R10 evicted word in memory", mem[7], 32'hD0D0_0004);
    chk(rd == truth[23], "R10 new line value", rd, truth[23]);

    // R7 own read retried
    retryAddr = 32'd40; retryBudget = retriesGiven + 1;
    cpuDo(0, 40, 0, rd);
    chk(countCmd(1, 40) == 2, "R7 read reissued after retry", 32'(countCmd(1, 40)), 32'd2);
    chk(rd == truth[40], "R7 reissued read value", rd, truth[40]);

    // R8 snoop priority
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 32'd5;
    snpCmd = 2'b01; snpAddr = 32'd9;
    #4;
    chk(!cpuReady, "R8 stalled during foreign command", 32'(cpuReady), 32'd0);
    @(negedge clk);
    snpCmd = 2'b00;
    #4;
    chk(cpuReady && cpuRdata == truth[5], "R8 completes after snoop", cpuRdata, truth[5]);
    @(negedge clk);
    cpuReq = 1'b0;

    // R12 request held until grant
    gntBlock = 1'b1;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 32'd41;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      #4;
      chk(busReq && busCmd == 2'b00, "R12 request held, no command", {30'd0, busReq, |busCmd}, 32'd2);
      @(negedge clk);
    end
    gntBlock = 1'b0;
    #4;
    chk(busCmd == 2'b01 && busAddr == 32'd41, "R12 command in granted cycle", busAddr, 32'd41);
    @(negedge clk);
    #4;
    chk(cpuReady && cpuRdata == truth[41], "R12 read completes", cpuRdata, truth[41]);
    @(negedge clk);
    cpuReq = 1'b0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule